// File: doc/BRIEF.md
# Two-Channel Prescaled One-Shot Timer

This block holds a set of independent one-shot interval timers (two by default). Each channel divides the core clock through its own 8-bit prescaler and uses the divided ticks to step a 16-bit counter down towards zero. Software starts a channel by writing a nonzero start value. Writing zero idles the channel. There is no separate enable bit.

When the counter reaches zero it stays there and the channel stops. A sticky completion flag is then set. Software clears the flag by writing a one to it. The flag drives the channel's interrupt line when the channel's interrupt enable is set.

A single-cycle register port gives access to every channel. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The word address is `channel*4 + offset`, with these offsets:

| Offset | Register | Access |
|---|---|---|
| 0 | divider setting | read/write |
| 1 | start value | write starts the channel, read returns the last value written |
| 2 | live count | read only |
| 3 | status and control | see below |

In the status and control register, bit 0 is the completion flag (a write of 1 clears it), bit 1 is the interrupt enable (read/write), and bit 2 is the running bit (read only).

Top module: `oneshot_timer`

## Requirements
- R1: After reset, every register of every channel reads 0 and every `irq` bit is low.
- R2: A write of a nonzero value V to offset 1 sets the live count (offset 2) to V and sets the running bit (status bit 2). Both are visible after the write edge.
- R3: With divider setting N (offset 0, bits 7:0), the count drops by one every N+1 clocks. The first drop comes N+1 clocks after the start write edge.
- R4: The count reaches 0 exactly V*(N+1) clocks after the start write. On that edge the running bit clears and the completion flag (status bit 0) sets. The count then holds at 0.
- R5: A write of 0 to offset 1 stops the channel with a count of 0. It does not set the completion flag.
- R6: A nonzero start write while the channel is running restarts the count from the new value. It also restarts the prescaler phase, so the next drop comes N+1 clocks later.
- R7: The completion flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves the flag unchanged.
- R8: `irq[c]` is high exactly when channel c's completion flag and its interrupt enable (status bit 1) are both set.
- R9: A write addressed to one channel changes no register of any other channel.
- R10: When expiry and a flag-clearing write fall on the same edge, the flag ends set. When expiry and a start write fall on the same edge, the start write wins: the count loads the new value and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Word address: channel in the upper bit(s), offset in bits 1:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 2 | Per-channel interrupt, completion flag AND enable |

## Verification
Random runs draw divider settings from 0 to 3 and start values from 1 to 12. Each run samples the count at a random point inside the interval and again after expiry. This separates an off-by-one in the prescaler period from an off-by-one in the terminal count. Directed cases then cover the edge interactions:
- a zero start write against a running count;
- a restart in mid-period, which shows whether the prescaler phase is cleared;
- a clear and a reload that land on the very edge of expiry.

One channel keeps running while the other is written, which exposes any crosstalk in the address decode.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Register offsets within one channel's window of four words.
  typedef enum logic [1:0] {
    OFS_DIV   = 2'd0,
    OFS_START = 2'd1,
    OFS_LIVE  = 2'd2,
    OFS_CTRL  = 2'd3
  } reg_ofs_e;

  // Bit positions in the status/control word.
  localparam int unsigned BIT_DONE = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_RUN  = 2;
  localparam int unsigned CTRL_W   = 3;

  // A divided tick is due once the phase has reached the divider setting.
  function automatic logic phase_due(input logic [7:0] phase, input logic [7:0] divider);
    return phase >= divider;
  endfunction

  // The count is on its final step when it equals one.
  function automatic logic last_step(input logic [15:0] value);
    return value == 16'd1;
  endfunction

endpackage

// File: rtl/ost_prescaler.sv
module ost_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] divider,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic             due;

  always_comb begin
    due  = (phase >= divider);
    tick = run && !restart && due;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || !run || due) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/ost_channel.sv
module ost_channel
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic             start_wr,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [PRE_W-1:0] div_q,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             done_q,
  output logic             ien_q,
  output logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ost_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (start_wr),
    .divider (div_q),
    .tick    (tick)
  );

  always_comb expire = tick && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_wr) begin
      div_q <= wdata[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (start_wr) begin
      start_q <= wdata;
      count_q <= wdata;
      run_q   <= (wdata != '0);
    end else if (tick) begin
      count_q <= count_q - ONE;
      if (count_q == ONE) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (expire) begin
        done_q <= 1'b1;
      end else if (ctrl_wr && wdata[BIT_DONE]) begin
        done_q <= 1'b0;
      end
      if (ctrl_wr) ien_q <= wdata[BIT_IEN];
    end
  end
endmodule

// File: rtl/ost_decode.sv
module ost_decode
  import oneshot_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 3
) (
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N_CH-1:0][PRE_W-1:0]  div_v,
  input  logic [N_CH-1:0][CNT_W-1:0]  start_v,
  input  logic [N_CH-1:0][CNT_W-1:0]  count_v,
  input  logic [N_CH-1:0][CTRL_W-1:0] ctrl_v,
  output logic [N_CH-1:0]             div_wr,
  output logic [N_CH-1:0]             start_wr,
  output logic [N_CH-1:0]             ctrl_wr,
  output logic [CNT_W-1:0]            rdata
);
  logic [CH_W-1:0] sel_ch;
  reg_ofs_e        sel_ofs;

  always_comb begin
    sel_ch  = addr[ADDR_W-1:2];
    sel_ofs = reg_ofs_e'(addr[1:0]);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_wr
    logic hit;
    always_comb begin
      hit         = we && (sel_ch == CH_W'(c));
      div_wr[c]   = hit && (sel_ofs == OFS_DIV);
      start_wr[c] = hit && (sel_ofs == OFS_START);
      ctrl_wr[c]  = hit && (sel_ofs == OFS_CTRL);
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (sel_ch == CH_W'(c)) begin
        unique case (sel_ofs)
          OFS_DIV:   rdata = CNT_W'(div_v[c]);
          OFS_START: rdata = start_v[c];
          OFS_LIVE:  rdata = count_v[c];
          OFS_CTRL:  rdata = CNT_W'(ctrl_v[c]);
        endcase
      end
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   irq
);
  logic [N_CH-1:0][PRE_W-1:0]  div_v;
  logic [N_CH-1:0][CNT_W-1:0]  start_v;
  logic [N_CH-1:0][CNT_W-1:0]  count_v;
  logic [N_CH-1:0][CTRL_W-1:0] ctrl_v;
  logic [N_CH-1:0]             div_wr;
  logic [N_CH-1:0]             start_wr;
  logic [N_CH-1:0]             ctrl_wr;
  logic [N_CH-1:0]             run_v;
  logic [N_CH-1:0]             done_v;
  logic [N_CH-1:0]             ien_v;
  logic [N_CH-1:0]             tick_v;
  logic [N_CH-1:0]             expire_v;

  ost_decode #(
    .N_CH(N_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .we       (bus_we),
    .addr     (bus_addr),
    .div_v    (div_v),
    .start_v  (start_v),
    .count_v  (count_v),
    .ctrl_v   (ctrl_v),
    .div_wr   (div_wr),
    .start_wr (start_wr),
    .ctrl_wr  (ctrl_wr),
    .rdata    (bus_rdata)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ost_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_wr   (div_wr[c]),
      .start_wr (start_wr[c]),
      .ctrl_wr  (ctrl_wr[c]),
      .wdata    (bus_wdata),
      .div_q    (div_v[c]),
      .start_q  (start_v[c]),
      .count_q  (count_v[c]),
      .run_q    (run_v[c]),
      .done_q   (done_v[c]),
      .ien_q    (ien_v[c]),
      .tick     (tick_v[c]),
      .expire   (expire_v[c])
    );
    always_comb begin
      ctrl_v[c]          = '0;
      ctrl_v[c][BIT_DONE] = done_v[c];
      ctrl_v[c][BIT_IEN]  = ien_v[c];
      ctrl_v[c][BIT_RUN]  = run_v[c];
      irq[c]             = done_v[c] && ien_v[c];
    end
  end
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CNT_W-1:0]           wdata,
  input logic [N_CH-1:0][CNT_W-1:0] count_v,
  input logic [N_CH-1:0]            start_wr,
  input logic [N_CH-1:0]            div_wr,
  input logic [N_CH-1:0]            ctrl_wr,
  input logic [N_CH-1:0]            run_v,
  input logic [N_CH-1:0]            done_v,
  input logic [N_CH-1:0]            tick_v,
  input logic [N_CH-1:0]            expire_v,
  input logic [N_CH-1:0]            irq
);
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_wr | div_wr | ctrl_wr));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr[c] && wdata != '0) |=> (run_v[c] && count_v[c] == $past(wdata)));

    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_v[c] |=> (count_v[c] == $past(count_v[c]) - 1'b1));

    assert_expire_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[c] |=> (done_v[c] && !run_v[c] && count_v[c] == '0));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[c] && !start_wr[c]) |=> $stable(count_v[c]));

    assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[c] |-> (count_v[c] != '0));

    assert_zero_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr[c] && wdata == '0) |=> (!run_v[c] && count_v[c] == '0 && $stable(done_v[c])));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v[c] && !ctrl_wr[c]) |=> done_v[c]);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> done_v[c]);
  end
endmodule

bind oneshot_timer oneshot_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wdata    (bus_wdata),
  .count_v  (count_v),
  .start_wr (start_wr),
  .div_wr   (div_wr),
  .ctrl_wr  (ctrl_wr),
  .run_v    (run_v),
  .done_v   (done_v),
  .tick_v   (tick_v),
  .expire_v (expire_v),
  .irq      (irq)
);

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  oneshot_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected values from the requirements (R3, R4).
  function automatic int exp_count(int v, int n, int c);
    if (c >= v * (n + 1)) return 0;
    return v - c / (n + 1);
  endfunction

  function automatic int exp_done(int v, int n, int c);
    return (c >= v * (n + 1)) ? 1 : 0;
  endfunction

  function automatic logic [2:0] adr(int ch, int ofs);
    return 3'(ch * 4 + ofs);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_cyc(int c);
    repeat (c) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reg(string req, int ch, int ofs, int exp);
    int v;
    rd(adr(ch, ofs), v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int ch = 0; ch < 2; ch++)
      for (int o = 0; o < 4; o++) chk_reg("R1", ch, o, 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4: divider 2, start 3
    wr(adr(0, 0), 16'd2);
    wr(adr(0, 1), 16'd3);
    chk_reg("R2 count", 0, 2, 3);
    chk_reg("R2 run", 0, 3, 3'b100);
    wait_cyc(2);  chk_reg("R3 before tick", 0, 2, 3);
    wait_cyc(1);  chk_reg("R3 first tick", 0, 2, 2);
    wait_cyc(5);  chk_reg("R4 pre-expiry", 0, 2, 1);
    wait_cyc(1);  chk_reg("R4 expired count", 0, 2, 0);
    chk_reg("R4 flag set run clear", 0, 3, 3'b001);
    wait_cyc(3);  chk_reg("R4 hold zero", 0, 2, 0);
    chk_reg("R1 readback start", 0, 1, 3);

    // R8/R7: enable without clearing, then clear
    check("R8 irq off", int'(irq[0]), 0);
    wr(adr(0, 3), 16'b010);
    check("R8 irq on", int'(irq[0]), 1);
    chk_reg("R7 write zero keeps flag", 0, 3, 3'b011);
    wr(adr(0, 3), 16'b011);
    chk_reg("R7 cleared", 0, 3, 3'b010);
    check("R8 irq off after clear", int'(irq[0]), 0);
    wr(adr(0, 3), 16'b000);

    // R5: zero start write stops
    wr(adr(0, 0), 16'd0);
    wr(adr(0, 1), 16'd5);
    wait_cyc(2);  chk_reg("R5 running count", 0, 2, 3);
    wr(adr(0, 1), 16'd0);
    chk_reg("R5 stopped count", 0, 2, 0);
    wait_cyc(10);
    chk_reg("R5 no flag", 0, 3, 0);

    // R6: restart mid-period resets phase
    wr(adr(0, 0), 16'd3);
    wr(adr(0, 1), 16'd4);
    wait_cyc(6);  chk_reg("R6 before reload", 0, 2, 3);
    wr(adr(0, 1), 16'd2);
    wait_cyc(3);  chk_reg("R6 no early tick", 0, 2, 2);
    wait_cyc(1);  chk_reg("R6 tick after full period", 0, 2, 1);
    wait_cyc(4);  chk_reg("R6 expiry", 0, 2, 0);
    chk_reg("R6 flag", 0, 3, 3'b001);
    wr(adr(0, 3), 16'b001);

    // R9: channel 1 running while channel 0 is written
    wr(adr(1, 0), 16'd1);
    wr(adr(1, 1), 16'd6);
    wr(adr(0, 0), 16'd7);
    wr(adr(0, 1), 16'd0);
    wait_cyc(9);  chk_reg("R9 ch1 count", 1, 2, 1);
    wait_cyc(1);  chk_reg("R9 ch1 expired", 1, 3, 3'b001);
    chk_reg("R9 ch0 flag untouched", 0, 3, 0);
    chk_reg("R9 ch0 divider", 0, 0, 7);
    chk_reg("R9 ch1 divider", 1, 0, 1);
    wr(adr(1, 3), 16'b001);

    // R10: clear on the expiry edge leaves the flag set
    wr(adr(0, 0), 16'd0);
    wr(adr(0, 1), 16'd2);
    wait_cyc(1);
    wr(adr(0, 3), 16'b001);
    chk_reg("R10 set beats clear", 0, 3, 3'b001);
    wr(adr(0, 3), 16'b001);
    chk_reg("R10 cleared", 0, 3, 0);
    // R10: start on the expiry edge wins
    wr(adr(0, 1), 16'd2);
    wait_cyc(1);
    wr(adr(0, 1), 16'd5);
    chk_reg("R10 reload count", 0, 2, 5);
    chk_reg("R10 reload no flag", 0, 3, 3'b100);
    wr(adr(0, 1), 16'd0);

    // Random runs: R3, R4, R8
    for (int it = 0; it < 24; it++) begin
      int ch = int'($urandom % 2);
      int n  = int'($urandom % 4);
      int v  = 1 + int'($urandom % 12);
      int total = v * (n + 1);
      int c1 = int'($urandom % total);
      int ien = int'($urandom % 2);
      wr(adr(ch, 3), 16'(1 + 2 * ien));
      wr(adr(ch, 0), 16'(n));
      wr(adr(ch, 1), 16'(v));
      wait_cyc(c1);
      chk_reg("R3 random mid count", ch, 2, exp_count(v, n, c1));
      chk_reg("R3 random mid flag", ch, 3, exp_done(v, n, c1) + 2 * ien + 4);
      wait_cyc(total - c1);
      chk_reg("R4 random end count", ch, 2, exp_count(v, n, total));
      chk_reg("R4 random end flag", ch, 3, exp_done(v, n, total) + 2 * ien);
      check("R8 random irq", int'(irq[ch]), ien);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule